// File: doc/BRIEF.md
# Divider-Driven Programmable Timer

A timer block that runs on the machine's base tick (one tick per clock cycle). A free-running 16-bit divider advances every tick. One of four divider bits, chosen by a rate select, is ANDed with an enable bit. A falling edge of that gated bit advances an 8-bit counter. When the counter rolls over, the reload from an 8-bit modulo register and the interrupt request are held back for a short pending window. A counter write by software during that window cancels both.

Software reaches the block through a byte-wide register port with a two-bit offset. The interrupt request stays high until the interrupt controller pulses the clear input.

Top module: `tick_timer`

## Requirements
- R1: The divider increments by one every tick outside a frozen window, wrapping from 0xFFFF to 0x0000. A read at offset 0 returns divider bits 15:8.
- R2: Any write to offset 0 sets the whole 16-bit divider to zero on the next edge, whatever the data.
- R3: Offset 1 is the counter, 2 the modulo, 3 the control register (bit 2 enable, bits 1:0 rate select; the other bits read as 0). Writes to modulo and control are visible on the next read.
- R4: Rate select 0, 1, 2, 3 monitors divider bit 9, 3, 5, 7. The counter increments on the tick where (selected bit AND enable) goes from 1 to 0. The state just after reset counts as 0.
- R5: A fall of the gated bit caused by a divider clear or by a control write (disable or select change) also increments the counter.
- R6: An increment from 0xFF makes the counter 0x00 and starts a pending window. No reload and no interrupt happen yet. For the next 4 ticks the divider holds its value.
- R7: The 5th tick after the overflow loads the modulo into the counter, raises the interrupt and resumes divider counting.
- R8: A counter write during the 4 frozen ticks stores the byte and cancels the reload and the interrupt of that overflow.
- R9: A counter write on the reload tick itself is lost; the counter takes the modulo value.
- R10: The interrupt output stays high until the clear input is high on a clock edge. A raise on the same edge wins over the clear.
- R11: Reset makes every register read 0, the interrupt low and the block not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 divider, 1 counter, 2 modulo, 3 control) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Timer interrupt request |
| irq_clr | input | 1 | Interrupt clear pulse |

## Verification
Register writes show up on the read port one edge after the strobe. A counter increment is visible one edge after the tick whose divider or control value made the gated bit fall. Overflow shows the counter at zero from that edge; the reload and the interrupt appear exactly five edges later. The bench drives all inputs at the falling edge and reads each result just after the rising edge where it is due. It compares the read data against a cycle model kept in bench functions, and also checks fixed constants for the overflow, abort and reload-tick cases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [1:0] OFS_DIV  = 2'd0;
    localparam logic [1:0] OFS_CNT  = 2'd1;
    localparam logic [1:0] OFS_MOD  = 2'd2;
    localparam logic [1:0] OFS_CTL  = 2'd3;
    localparam int         CTL_EN_BIT = 2;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_PEND  = 2'd1,
        PH_ABORT = 2'd2
    } phase_e;
endpackage

// File: rtl/tmr_tap_select.sv
module tmr_tap_select #(
    parameter int DIV_W = 16,
    parameter int TAP0  = 9,
    parameter int TAP1  = 3,
    parameter int TAP2  = 5,
    parameter int TAP3  = 7
) (
    input  logic [DIV_W-1:0] div_val,
    input  logic             enable,
    input  logic [1:0]       rate_sel,
    output logic             gated
);
    logic picked;

    always_comb begin
        unique case (rate_sel)
            2'd0:    picked = div_val[TAP0];
            2'd1:    picked = div_val[TAP1];
            2'd2:    picked = div_val[TAP2];
            default: picked = div_val[TAP3];
        endcase
        gated = picked & enable;
    end
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux #(
    parameter int DIV_W = 16
) (
    input  logic [1:0]       reg_addr,
    input  logic [DIV_W-1:0] div_val,
    input  logic [7:0]       cnt_val,
    input  logic [7:0]       mod_val,
    input  logic             enable,
    input  logic [1:0]       rate_sel,
    output logic [7:0]       rd_data
);
    import tmr_pkg::*;

    always_comb begin
        rd_data = '0;
        unique case (reg_addr)
            OFS_DIV: rd_data = div_val[DIV_W-1 -: 8];
            OFS_CNT: rd_data = cnt_val;
            OFS_MOD: rd_data = mod_val;
            default: begin
                rd_data[CTL_EN_BIT] = enable;
                rd_data[1:0]        = rate_sel;
            end
        endcase
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int DIV_W      = 16,
    parameter int PEND_STEPS = 4,
    parameter int TAP0       = 9,
    parameter int TAP1       = 3,
    parameter int TAP2       = 5,
    parameter int TAP3       = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] reg_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq,
    input  logic       irq_clr
);
    import tmr_pkg::*;

    localparam int STEP_W = $clog2(PEND_STEPS + 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(PEND_STEPS);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [7:0]        cnt;
        logic [7:0]        mod;
        logic              en;
        logic [1:0]        sel;
        logic              gate;
        phase_e            phase;
        logic [STEP_W-1:0] step;
        logic              irq;
    } tmr_state_t;

    tmr_state_t st_q, st_d;

    logic             wr_div, wr_cnt, wr_mod, wr_ctl;
    logic             frozen;
    logic [DIV_W-1:0] div_nx;
    logic             en_nx;
    logic [1:0]       sel_nx;
    logic             gate_now;

    // decode and the values the tap looks at this tick
    always_comb begin
        wr_div = wr_en && (reg_addr == OFS_DIV);
        wr_cnt = wr_en && (reg_addr == OFS_CNT);
        wr_mod = wr_en && (reg_addr == OFS_MOD);
        wr_ctl = wr_en && (reg_addr == OFS_CTL);
        frozen = (st_q.phase != PH_RUN) && (st_q.step < STEP_LAST);
        if (wr_div)      div_nx = '0;
        else if (frozen) div_nx = st_q.div;
        else             div_nx = st_q.div + 1'b1;
        en_nx  = wr_ctl ? wr_data[CTL_EN_BIT] : st_q.en;
        sel_nx = wr_ctl ? wr_data[1:0]        : st_q.sel;
    end

    tmr_tap_select #(
        .DIV_W(DIV_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
    ) u_tap (
        .div_val  (div_nx),
        .enable   (en_nx),
        .rate_sel (sel_nx),
        .gated    (gate_now)
    );

    // next-state computation
    always_comb begin
        logic [7:0] base;
        logic       fall;
        logic       raise;

        st_d     = st_q;
        st_d.div = div_nx;
        st_d.en  = en_nx;
        st_d.sel = sel_nx;
        if (wr_mod) st_d.mod = wr_data;
        base  = st_q.cnt;
        fall  = 1'b0;
        raise = 1'b0;

        if (frozen) begin
            // pending window: only the step count moves
            st_d.step = st_q.step + 1'b1;
            if (wr_cnt) begin
                st_d.cnt = wr_data;
                if (st_q.phase == PH_PEND) st_d.phase = PH_ABORT;
            end
        end else begin
            if (st_q.phase == PH_PEND) begin
                base  = st_q.mod;
                raise = 1'b1;
            end
            st_d.phase = PH_RUN;
            st_d.step  = '0;
            fall       = st_q.gate & ~gate_now;
            st_d.gate  = gate_now;
            if (wr_cnt && (st_q.phase != PH_PEND)) begin
                st_d.cnt = wr_data;
            end else if (fall) begin
                if (base == 8'hFF) begin
                    st_d.cnt   = 8'h00;
                    st_d.phase = PH_PEND;
                end else begin
                    st_d.cnt = base + 8'd1;
                end
            end else begin
                st_d.cnt = base;
            end
        end

        if (raise)        st_d.irq = 1'b1;
        else if (irq_clr) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    tmr_read_mux #(.DIV_W(DIV_W)) u_rd (
        .reg_addr (reg_addr),
        .div_val  (st_q.div),
        .cnt_val  (st_q.cnt),
        .mod_val  (st_q.mod),
        .enable   (st_q.en),
        .rate_sel (st_q.sel),
        .rd_data  (rd_data)
    );

    assign irq = st_q.irq;

    // named views used by the bound checker
    logic [DIV_W-1:0]  div_cur;
    logic [7:0]        cnt_cur;
    logic [1:0]        phase_cur;
    logic [STEP_W-1:0] step_cur;
    assign div_cur   = st_q.div;
    assign cnt_cur   = st_q.cnt;
    assign phase_cur = st_q.phase;
    assign step_cur  = st_q.step;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int DIV_W      = 16,
    parameter int PEND_STEPS = 4,
    parameter int STEP_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        reg_addr,
    input logic              irq,
    input logic              irq_clr,
    input logic [DIV_W-1:0]  div_cur,
    input logic [7:0]        cnt_cur,
    input logic [1:0]        phase_cur,
    input logic [STEP_W-1:0] step_cur
);
    localparam logic [1:0] RUN   = 2'd0;
    localparam logic [1:0] PEND  = 2'd1;
    localparam logic [1:0] ABORT = 2'd2;
    localparam logic [STEP_W-1:0] LAST = STEP_W'(PEND_STEPS);

    p_div_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == 2'd0) |=> (div_cur == '0));

    p_frozen_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cur != RUN && step_cur < LAST && !(wr_en && reg_addr == 2'd0))
        |=> (div_cur == $past(div_cur)));

    p_pend_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cur == PEND && $past(phase_cur) == RUN) |-> (cnt_cur == 8'h00 && step_cur == '0));

    p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_cur <= LAST);

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(phase_cur) == PEND && $past(step_cur) == LAST));

    p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cur == ABORT && step_cur == LAST && !irq) |=> !irq);

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

bind tick_timer tick_timer_chk #(
    .DIV_W(DIV_W), .PEND_STEPS(PEND_STEPS), .STEP_W(STEP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_addr  (reg_addr),
    .irq       (irq),
    .irq_clr   (irq_clr),
    .div_cur   (div_cur),
    .cnt_cur   (cnt_cur),
    .phase_cur (phase_cur),
    .step_cur  (step_cur)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;
    logic       irq_clr = 1'b0;

    always #10 clk = ~clk;

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .irq_clr(irq_clr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench cycle model
    logic [15:0] m_div;
    logic [7:0]  m_cnt, m_mod;
    logic        m_en, m_gate, m_irq;
    logic [1:0]  m_sel;
    int          m_ph;    // 0 run, 1 pending, 2 aborted
    int          m_step;

    function automatic int tap_of(logic [1:0] s);
        case (s)
            2'd0: return 9;
            2'd1: return 3;
            2'd2: return 5;
            default: return 7;
        endcase
    endfunction

    function automatic logic [7:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return m_div[15:8];
            2'd1: return m_cnt;
            2'd2: return m_mod;
            default: return {5'd0, m_en, m_sel};
        endcase
    endfunction

    task automatic model_reset();
        m_div = 0; m_cnt = 0; m_mod = 0; m_en = 0; m_sel = 0;
        m_gate = 0; m_irq = 0; m_ph = 0; m_step = 0;
    endtask

    task automatic model_tick(bit we, logic [1:0] a, logic [7:0] d, bit clr);
        bit frz, g, fall, up;
        logic [7:0] base, mod_old;
        frz = (m_ph != 0) && (m_step < 4);
        if (we && a == 0) m_div = 0;
        else if (!frz)    m_div = m_div + 1;
        if (we && a == 3) begin m_en = d[2]; m_sel = d[1:0]; end
        mod_old = m_mod;
        if (we && a == 2) m_mod = d;
        up = 0;
        if (frz) begin
            m_step++;
            if (we && a == 1) begin
                m_cnt = d;
                if (m_ph == 1) m_ph = 2;
            end
        end else begin
            base = m_cnt;
            if (m_ph == 1) begin base = mod_old; up = 1; end
            g = m_div[tap_of(m_sel)] & m_en;
            fall = m_gate & !g;
            m_gate = g;
            m_step = 0;
            if (we && a == 1 && m_ph != 1) begin
                m_cnt = d; m_ph = 0;
            end else if (fall && base == 8'hFF) begin
                m_cnt = 0; m_ph = 1;
            end else begin
                m_cnt = fall ? base + 8'd1 : base; m_ph = 0;
            end
        end
        if (up) m_irq = 1;
        else if (clr) m_irq = 0;
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one tick with the given inputs; returns just after the edge
    task automatic cyc(bit we = 0, logic [1:0] a = 0, logic [7:0] d = 0, bit clr = 0);
        @(negedge clk);
        wr_en = we; reg_addr = a; wr_data = d; irq_clr = clr;
        @(posedge clk);
        model_tick(we, a, d, clr);
        #1;
        wr_en = 0; irq_clr = 0;
    endtask

    task automatic peek(string req, logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = rd_data;
        chk(req, {8'd0, v}, {8'd0, model_read(a)});
    endtask

    task automatic wait_pend();
        for (int i = 0; i < 200 && m_ph != 1; i++) cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, prev;
        int unsigned seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            peek("R11", 2'(a), v);
            chk("R11 reset value", {8'd0, v}, 16'h0000);
        end
        chk("R11 irq after reset", {15'd0, irq}, 16'd0);

        // R1 divider counting and wrap
        repeat (700) cyc();
        peek("R1 divider high byte", 2'd0, v);
        chk("R1 divider after 700", {8'd0, v}, 16'h0002);
        repeat (65536) cyc();
        peek("R1 divider after wrap", 2'd0, v);
        chk("R1 wrap value", {8'd0, v}, 16'h0002);

        // R2 divider clear
        cyc(1, 2'd0, 8'h5A);
        peek("R2 divider cleared", 2'd0, v);
        chk("R2 clear value", {8'd0, v}, 16'h0000);

        // R3 register map
        cyc(1, 2'd2, 8'hA5);
        peek("R3 modulo readback", 2'd2, v);
        chk("R3 modulo value", {8'd0, v}, 16'h00A5);
        cyc(1, 2'd3, 8'hFB);
        peek("R3 control readback", 2'd3, v);
        chk("R3 control masked", {8'd0, v}, 16'h0003);

        // R4 falling edge on bit 3 after 16 ticks
        cyc(1, 2'd1, 8'h00);
        cyc(1, 2'd3, 8'h05);
        cyc(1, 2'd0, 8'h00);
        repeat (15) cyc();
        peek("R4 before edge", 2'd1, v);
        chk("R4 no count yet", {8'd0, v}, 16'h0000);
        cyc();
        peek("R4 after edge", 2'd1, v);
        chk("R4 one count", {8'd0, v}, 16'h0001);

        // R5 control write and divider clear cause a fall
        for (int i = 0; i < 40 && !(m_div[3] && m_en); i++) cyc();
        peek("R5 pre", 2'd1, prev);
        cyc(1, 2'd3, 8'h01);
        peek("R5 disable fall", 2'd1, v);
        chk("R5 disable counts", {8'd0, v}, {8'd0, prev + 8'd1});
        cyc(1, 2'd3, 8'h05);
        for (int i = 0; i < 40 && !m_div[3]; i++) cyc();
        peek("R5 pre2", 2'd1, prev);
        cyc(1, 2'd0, 8'h00);
        peek("R5 clear fall", 2'd1, v);
        chk("R5 clear counts", {8'd0, v}, {8'd0, prev + 8'd1});

        // R6 / R7 overflow, frozen window, reload
        cyc(1, 2'd2, 8'h40);
        cyc(1, 2'd1, 8'hFF);
        wait_pend();
        peek("R6 counter zero", 2'd1, v);
        chk("R6 zero at overflow", {8'd0, v}, 16'h0000);
        chk("R6 no irq yet", {15'd0, irq}, 16'd0);
        for (int i = 0; i < 4; i++) begin
            cyc();
            peek("R6 frozen", 2'd1, v);
            chk("R6 no reload", {8'd0, v}, 16'h0000);
            chk("R6 irq low", {15'd0, irq}, 16'd0);
        end
        cyc();
        peek("R7 reload", 2'd1, v);
        chk("R7 reload value", {8'd0, v}, 16'h0040);
        chk("R7 irq raised", {15'd0, irq}, 16'd1);

        // R10 hold and clear
        repeat (10) cyc();
        chk("R10 irq held", {15'd0, irq}, 16'd1);
        cyc(0, 2'd0, 8'd0, 1);
        chk("R10 irq cleared", {15'd0, irq}, 16'd0);

        // R8 abort
        cyc(1, 2'd1, 8'hFF);
        wait_pend();
        cyc(); cyc();
        cyc(1, 2'd1, 8'h77);
        repeat (3) cyc();
        peek("R8 abort keeps write", 2'd1, v);
        chk("R8 written value kept", {8'd0, v}, 16'h0077);
        chk("R8 no irq", {15'd0, irq}, 16'd0);

        // R9 write on the reload tick
        cyc(1, 2'd1, 8'hFF);
        wait_pend();
        repeat (4) cyc();
        cyc(1, 2'd1, 8'h11);
        peek("R9 reload wins", 2'd1, v);
        chk("R9 reload value", {8'd0, v}, 16'h0040);
        chk("R9 irq raised", {15'd0, irq}, 16'd1);
        cyc(0, 2'd0, 8'd0, 1);

        // constrained random against the model (R1..R10)
        for (int i = 0; i < 6000; i++) begin
            int unsigned r;
            bit we, clr;
            logic [1:0] a;
            logic [7:0] d;
            r   = $urandom;
            we  = (r[3:0] == 0);
            a   = r[5:4];
            if (a == 2'd0 && r[8:6] != 0) we = 0;
            d   = r[15:8];
            if (a == 2'd1 && r[16]) d = 8'hF0 | d;
            if (a == 2'd3) d[2] = 1'b1;
            clr = (r[23:20] == 0);
            cyc(we, a, d, clr);
            peek("R4 R6 R7 R8 random read", 2'(r[25:24]), v);
            chk("R10 random irq", {15'd0, irq}, {15'd0, m_irq});
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule